// File: doc/BRIEF.md
# Auto-Increment Word Program Sequencer

This block writes a byte range of any length and alignment into a serial NOR flash that supports a word-program mode. In this mode the address is sent once and then advances by itself, two bytes per program cycle. The host pulses `start` with a start address and a byte count. It then supplies the data bytes through a valid/ready stream. The block turns the request into a series of command frames for an external SPI byte shifter, one byte at a time. The shifter acknowledges each byte with `spi_done` and returns the byte it received.

A start address that is odd is handled with a single-byte program before the word cycles begin. A single byte left at the end is handled the same way, inside its own write-enable / write-disable pair. The block polls the flash status register between program operations. It gives up with an error if the flash stays busy for too many consecutive status reads. A running count of the data bytes sent to the flash is reported throughout.

Top module: `aai_prog_engine`

## Requirements
- R1: While reset is high and after it is released, `busy`, `done`, `error`, `spi_start` and `data_ready` are 0 and `bytes_written` is 0.
- R2: A `start` with `length` 0 produces a one-cycle `done` on the next cycle with `error` 0. No `spi_start` is issued.
- R3: Every request with nonzero length opens with a status poll. A poll is a two-byte frame: 0x05, then a dummy 0x00 marked last. Bit 0 of the byte returned for the dummy is the busy flag. The poll frame repeats until that bit is 0. The poll is followed by a one-byte write-enable frame 0x06.
- R4: If the start address is odd, the first program frame is 0x02, followed by three address bytes (most significant first) and one data byte marked last. A status poll follows it.
- R5: The first word frame is 0xAD, then the three address bytes of the next unwritten location, then two data bytes (the second marked last). A status poll follows it.
- R6: Each following word frame carries only 0xAD and two data bytes, with no address bytes. A status poll follows each one.
- R7: Once fewer than two bytes remain, a one-byte write-disable frame 0x04 is sent, followed by a status poll.
- R8: If exactly one byte then remains, the block sends 0x06, then 0x02 with the address start+length-1 and that byte, then a poll, then 0x04. After that it raises `done`.
- R9: If one poll sees the busy bit set on POLL_LIMIT consecutive reads, the request ends at once: `done` pulses, `error` goes to 1 and no further frame is sent. If the busy bit clears on read POLL_LIMIT, the request continues. `error` clears on the next `start`.
- R10: `bytes_written` counts the data bytes handed to the shifter since the last `start` and equals `length` when a request completes. It does not change while the block is idle.
- R11: `spi_start` is a one-cycle pulse and is never raised while a byte is waiting for `spi_done`. A data byte is consumed only in a cycle where both `data_valid` and `data_ready` are high. Gaps in `data_valid` delay the frames but do not change their content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse; accepted only while idle |
| start_addr | input | ADDR_W | Flash byte address of the first byte |
| length | input | LEN_W | Number of bytes to write |
| data_in | input | 8 | Next data byte of the stream |
| data_valid | input | 1 | `data_in` holds a byte |
| data_ready | output | 1 | Block takes `data_in` this cycle if valid |
| spi_start | output | 1 | Pulse: shift `spi_tx` out |
| spi_tx | output | 8 | Byte to transmit |
| spi_last | output | 1 | This byte ends the frame (chip select released after it) |
| spi_done | input | 1 | Shifter finished the outstanding byte |
| spi_rx | input | 8 | Byte received during the finished byte |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse at the end of a request |
| error | output | 1 | Last request aborted on a poll timeout |
| bytes_written | output | LEN_W | Data bytes sent in the current or last request |

## Verification
Two of the block's functions can fall in the same cycle. On the final allowed status read, the timeout decision and the resume-after-ready decision are both taken on one `spi_done` edge, and which one wins depends on a single bit. The bench provokes this by holding the flash busy for exactly POLL_LIMIT-1 reads, which must continue, and for POLL_LIMIT reads, which must abort with no write-enable sent. A second overlap arises because a data slot can be reached in a cycle where the stream is stalled. The bench withdraws `data_valid` on a fixed rhythm so that stalls land on data slots. It then requires the byte sequence, compared on every clock against a behavioural model, to come out the same as in an unstalled run.

// File: rtl/aai_pkg.sv
package aai_pkg;

  localparam logic [7:0] OP_STATUS    = 8'h05;
  localparam logic [7:0] OP_WR_EN     = 8'h06;
  localparam logic [7:0] OP_WR_DIS    = 8'h04;
  localparam logic [7:0] OP_BYTE_PROG = 8'h02;
  localparam logic [7:0] OP_WORD_PROG = 8'hAD;

  typedef enum logic [2:0] {
    K_POLL,
    K_WREN,
    K_WRDI,
    K_BYTE,
    K_WORD
  } frame_kind_e;

  typedef enum logic [1:0] {
    N_START,
    N_BODY,
    N_TAIL,
    N_TWRDI
  } resume_e;

endpackage

// File: rtl/aai_addr_track.sv
module aai_addr_track #(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [LEN_W-1:0]  load_len,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic [LEN_W-1:0]  rem,
  output logic [LEN_W-1:0]  count
);

  // One step per data byte: +1 after the odd lead byte, +2 per word frame.
  always_ff @(posedge clk) begin
    if (rst) begin
      addr  <= '0;
      rem   <= '0;
      count <= '0;
    end else if (load) begin
      addr  <= load_addr;
      rem   <= load_len;
      count <= '0;
    end else if (step) begin
      addr  <= addr + 1'b1;
      rem   <= rem - 1'b1;
      count <= count + 1'b1;
    end
  end

  // R10: a data byte is only taken while bytes remain
  assert_no_underflow_R10: assert property (@(posedge clk) disable iff (rst)
    step |-> (rem != '0));

  // R10: the count only grows between loads
  assert_count_monotonic_R10: assert property (@(posedge clk) disable iff (rst)
    !load |=> (count >= $past(count)));

endmodule

// File: rtl/aai_poll_timer.sv
module aai_poll_timer #(
  parameter int LIMIT = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic tick,
  output logic last
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (tick)    cnt <= cnt + 1'b1;
  end

  // High while the read in flight is the last one a poll may spend.
  assign last = (cnt == CW'(LIMIT - 1));

  // R9: the sequencer never retries past the allowed number of reads
  assert_tick_bounded_R9: assert property (@(posedge clk) disable iff (rst)
    tick |-> (cnt < CW'(LIMIT - 1)));

endmodule

// File: rtl/aai_prog_engine.sv
module aai_prog_engine
  import aai_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int LEN_W      = 16,
  parameter int POLL_LIMIT = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  length,
  input  logic [7:0]        data_in,
  input  logic              data_valid,
  output logic              data_ready,
  output logic              spi_start,
  output logic [7:0]        spi_tx,
  output logic              spi_last,
  input  logic              spi_done,
  input  logic [7:0]        spi_rx,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [LEN_W-1:0]  bytes_written
);

  localparam int AB    = ADDR_W / 8;
  localparam int IDX_W = $clog2(AB + 4);

  logic              run_q, wait_q, trail_q, first_q;
  frame_kind_e       kind_q, body_kind;
  resume_e           nxt_q;
  logic [IDX_W-1:0]  idx_q, naddr, flen_m1;
  logic [ADDR_W-1:0] trk_addr;
  logic [LEN_W-1:0]  trk_rem, trk_count;
  logic [7:0]        op_byte, addr_byte, cur_byte;
  logic              is_addr, is_data, at_end, can_issue, frame_end;
  logic              accept_start, rx_busy, tmr_clear, tmr_tick, tmr_last;
  logic              unused_rx;

  aai_addr_track #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_track (
    .clk(clk), .rst(rst), .load(accept_start), .load_addr(start_addr),
    .load_len(length), .step(can_issue && is_data),
    .addr(trk_addr), .rem(trk_rem), .count(trk_count)
  );

  aai_poll_timer #(.LIMIT(POLL_LIMIT)) u_timer (
    .clk(clk), .rst(rst), .clear(tmr_clear), .tick(tmr_tick), .last(tmr_last)
  );

  // Frame geometry: opcode, optional address bytes, data or dummy bytes.
  always_comb begin
    naddr = ((kind_q == K_BYTE) || (kind_q == K_WORD && first_q)) ? IDX_W'(AB) : '0;
    case (kind_q)
      K_POLL, K_BYTE: flen_m1 = naddr + IDX_W'(1);
      K_WORD:         flen_m1 = naddr + IDX_W'(2);
      default:        flen_m1 = '0;
    endcase
    case (kind_q)
      K_POLL:  op_byte = OP_STATUS;
      K_WREN:  op_byte = OP_WR_EN;
      K_WRDI:  op_byte = OP_WR_DIS;
      K_BYTE:  op_byte = OP_BYTE_PROG;
      default: op_byte = OP_WORD_PROG;
    endcase
    is_addr   = (idx_q != '0) && (idx_q <= naddr);
    is_data   = (idx_q > naddr) && (kind_q == K_BYTE || kind_q == K_WORD);
    at_end    = (idx_q == flen_m1);
    addr_byte = 8'(trk_addr >> (8 * (AB - int'(idx_q))));
    if (idx_q == '0)  cur_byte = op_byte;
    else if (is_addr) cur_byte = addr_byte;
    else if (is_data) cur_byte = data_in;
    else              cur_byte = 8'h00;
  end

  assign accept_start  = !run_q && start;
  assign data_ready    = run_q && !wait_q && is_data;
  assign can_issue     = run_q && !wait_q && (!is_data || data_valid);
  assign frame_end     = run_q && wait_q && spi_done && at_end;
  assign rx_busy       = spi_rx[0];
  assign unused_rx     = ^spi_rx[7:1];
  assign body_kind     = (trk_rem >= LEN_W'(2)) ? K_WORD : K_WRDI;
  assign tmr_clear     = accept_start
                       || (frame_end && (kind_q inside {K_BYTE, K_WORD}))
                       || (frame_end && kind_q == K_WRDI && !trail_q);
  assign tmr_tick      = frame_end && kind_q == K_POLL && rx_busy && !tmr_last;
  assign busy          = run_q;
  assign bytes_written = trk_count;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0; wait_q <= 1'b0; trail_q <= 1'b0; first_q <= 1'b0;
      kind_q <= K_POLL; nxt_q <= N_START; idx_q <= '0;
      spi_start <= 1'b0; spi_tx <= 8'h00; spi_last <= 1'b0;
      done <= 1'b0; error <= 1'b0;
    end else begin
      spi_start <= 1'b0;
      done      <= 1'b0;
      if (accept_start) begin
        error <= 1'b0; trail_q <= 1'b0; first_q <= 1'b1; wait_q <= 1'b0;
        idx_q <= '0; kind_q <= K_POLL; nxt_q <= N_START;
        if (length == '0) done <= 1'b1;
        else              run_q <= 1'b1;
      end else if (can_issue) begin
        spi_start <= 1'b1;
        spi_tx    <= cur_byte;
        spi_last  <= at_end;
        wait_q    <= 1'b1;
      end else if (run_q && wait_q && spi_done) begin
        wait_q <= 1'b0;
        if (!at_end) begin
          idx_q <= idx_q + 1'b1;
        end else begin
          idx_q <= '0;
          case (kind_q)
            K_POLL: begin
              if (rx_busy) begin
                if (tmr_last) begin
                  error <= 1'b1; run_q <= 1'b0; done <= 1'b1;
                end
              end else begin
                case (nxt_q)
                  N_START: kind_q <= K_WREN;
                  N_BODY:  kind_q <= body_kind;
                  N_TWRDI: kind_q <= K_WRDI;
                  default: begin
                    if (trk_rem == LEN_W'(1)) begin
                      trail_q <= 1'b1; kind_q <= K_WREN;
                    end else begin
                      run_q <= 1'b0; done <= 1'b1;
                    end
                  end
                endcase
              end
            end
            K_WREN: kind_q <= (trail_q || trk_addr[0]) ? K_BYTE : body_kind;
            K_BYTE: begin
              kind_q <= K_POLL;
              nxt_q  <= trail_q ? N_TWRDI : N_BODY;
            end
            K_WORD: begin
              kind_q <= K_POLL; nxt_q <= N_BODY; first_q <= 1'b0;
            end
            default: begin
              if (trail_q) begin
                run_q <= 1'b0; done <= 1'b1;
              end else begin
                kind_q <= K_POLL; nxt_q <= N_TAIL;
              end
            end
          endcase
        end
      end
    end
  end

  // R11: each shifter request lasts one cycle
  assert_start_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    spi_start |=> !spi_start);

  // R11: an accepted data byte goes to the shifter on the next cycle
  assert_accept_issue_R11: assert property (@(posedge clk) disable iff (rst)
    (data_valid && data_ready) |=> spi_start);

  // R2: completion is a single-cycle pulse
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: an aborted request leaves the block idle
  assert_err_idle_R9: assert property (@(posedge clk) disable iff (rst)
    error |-> !busy);

  // R10: the byte count holds while idle
  assert_count_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(bytes_written));

endmodule

// File: tb/aai_prog_engine_tb_top.sv
module aai_prog_engine_tb_top;

  localparam int ADDR_W = 24;
  localparam int LEN_W  = 16;
  localparam int LIMIT  = 8;
  localparam int AB     = ADDR_W / 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] start_addr = '0;
  logic [LEN_W-1:0]  length = '0;
  logic [7:0]        data_in = 8'h00;
  logic              data_valid = 1'b0;
  logic              data_ready;
  logic              spi_start;
  logic [7:0]        spi_tx;
  logic              spi_last;
  logic              spi_done = 1'b0;
  logic [7:0]        spi_rx = 8'h00;
  logic              busy, done, error;
  logic [LEN_W-1:0]  bytes_written;

  always #4 clk = ~clk;

  aai_prog_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .POLL_LIMIT(LIMIT)) dut_i (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr), .length(length),
    .data_in(data_in), .data_valid(data_valid), .data_ready(data_ready),
    .spi_start(spi_start), .spi_tx(spi_tx), .spi_last(spi_last),
    .spi_done(spi_done), .spi_rx(spi_rx), .busy(busy), .done(done),
    .error(error), .bytes_written(bytes_written)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [7:0] dq[$];
  logic [8:0] eq[$];
  string      et[$];
  int busy_n = 0, busy_left = 0, dn = 0, fidx = 0;
  logic [7:0] fop = 8'h00, resp = 8'h00;
  logic take = 1'b0;
  bit stall = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b, input bit last, input string tag);
    eq.push_back({last, b});
    et.push_back(tag);
  endtask

  task automatic push_poll(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      push(8'h05, 1'b0, tag);
      push(8'h00, 1'b1, tag);
    end
  endtask

  task automatic push_addr(input int a, input string tag);
    for (int k = AB - 1; k >= 0; k--) push(8'(a >> (8 * k)), 1'b0, tag);
  endtask

  // Behavioural model of the frame sequence, from the requirements.
  task automatic build(input int a0, input int len, input int bn);
    int a, r, i;
    bit first;
    a = a0; r = len; i = 0; first = 1'b1;
    if (len == 0) return;
    if (bn >= LIMIT) begin
      push_poll(LIMIT, "R9");                     // R9 abort after the limit
      return;
    end
    push_poll(bn + 1, "R3");                      // R3 opening poll
    push(8'h06, 1'b1, "R3");                      // R3 write enable
    if (a % 2 == 1) begin                         // R4 leading odd byte
      push(8'h02, 1'b0, "R4"); push_addr(a, "R4");
      push(dq[i], 1'b1, "R4");
      push_poll(bn + 1, "R4");
      i++; a++; r--;
    end
    while (r >= 2) begin                          // R5 first word, R6 later words
      push(8'hAD, 1'b0, first ? "R5" : "R6");
      if (first) push_addr(a, "R5");
      push(dq[i], 1'b0, first ? "R5" : "R6");
      push(dq[i+1], 1'b1, first ? "R5" : "R6");
      push_poll(bn + 1, first ? "R5" : "R6");
      i += 2; a += 2; r -= 2; first = 1'b0;
    end
    push(8'h04, 1'b1, "R7");                      // R7 write disable then poll
    push_poll(bn + 1, "R7");
    if (r == 1) begin                             // R8 trailing byte
      push(8'h06, 1'b1, "R8");
      push(8'h02, 1'b0, "R8"); push_addr(a, "R8");
      push(dq[i], 1'b1, "R8");
      push_poll(bn + 1, "R8");
      push(8'h04, 1'b1, "R8");
    end
  endtask

  task automatic run_case(input int a, input int len, input int bn, input bit stl, input string tag);
    bit exp_err;
    int exp_cnt;
    dq.delete();
    for (int i = 0; i < len; i++) dq.push_back(8'(a * 3 + i * 29 + 17));
    eq.delete(); et.delete();
    busy_n = bn; busy_left = bn; stall = stl; fidx = 0;
    build(a, len, bn);
    exp_err = (len > 0) && (bn >= LIMIT);
    exp_cnt = exp_err ? 0 : len;
    @(negedge clk);
    start = 1'b1; start_addr = ADDR_W'(a); length = LEN_W'(len);
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 20000; k++) begin
      if (done) break;
      @(negedge clk);
    end
    chk(done == 1'b1, tag, done, 1);
    chk(error == exp_err, "R9", error, exp_err);
    chk(bytes_written == LEN_W'(exp_cnt), "R10", bytes_written, exp_cnt);
    repeat (6) @(negedge clk);
    chk(eq.size() == 0, tag, eq.size(), 0);
    chk(busy == 1'b0, tag, busy, 0);
    chk(bytes_written == LEN_W'(exp_cnt), "R10", bytes_written, exp_cnt); // R10 idle hold
    dq.delete(); eq.delete(); et.delete();
  endtask

  // Shifter and flash responder, data stream and per-clock comparison.
  always @(negedge clk) begin
    logic [8:0] e;
    string t;
    cyc++;
    if (take) void'(dq.pop_front());
    spi_done = 1'b0;
    if (dn > 0) begin
      dn--;
      if (dn == 0) begin
        spi_done = 1'b1;
        spi_rx   = resp;
      end
    end
    if (spi_start) begin
      chk(dn == 0 && !spi_done, "R11", dn, 0);    // R11 one byte outstanding
      if (eq.size() == 0) begin
        chk(1'b0, "R9", {spi_last, spi_tx}, 0);   // R2 / R9 no frame expected
      end else begin
        e = eq.pop_front();
        t = et.pop_front();
        chk({spi_last, spi_tx} == e, t, {spi_last, spi_tx}, e);
      end
      if (fidx == 1 && fop == 8'h05) begin
        if (busy_left > 0) begin resp = 8'h03; busy_left--; end
        else begin resp = 8'h02; busy_left = busy_n; end
      end else begin
        resp = 8'hA5;
      end
      if (fidx == 0) fop = spi_tx;
      fidx = spi_last ? 0 : fidx + 1;
      dn = 3;
    end
    data_valid = (dq.size() > 0) && !(stall && (cyc % 3 == 0));
    data_in    = (dq.size() > 0) ? dq[0] : 8'h00;
    take       = data_valid && data_ready;
    if (cyc == 150000) begin
      checks++; errors++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0 && done == 1'b0 && error == 1'b0, "R1", {busy, done, error}, 0);
    chk(spi_start == 1'b0 && data_ready == 1'b0, "R1", {spi_start, data_ready}, 0);
    chk(bytes_written == '0, "R1", bytes_written, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0 && bytes_written == '0, "R1", busy, 0);

    run_case(32'h000040, 0, 0, 1'b0, "R2");       // R2 empty request
    run_case(32'h000100, 6, 0, 1'b0, "R6");       // R5 R6 R7 even, words only
    run_case(32'h12345F, 6, 2, 1'b1, "R8");       // R4 R8 odd ends, stalled R11
    run_case(32'h000200, 1, 1, 1'b0, "R8");       // R8 lone trailing byte
    run_case(32'h000301, 1, 0, 1'b0, "R4");       // R4 lone leading byte
    run_case(32'h00FFFD, 9, LIMIT - 1, 1'b1, "R9"); // R9 ready on last read
    run_case(32'h000400, 4, LIMIT, 1'b0, "R9");   // R9 timeout abort
    run_case(32'h000502, 3, 0, 1'b0, "R9");       // R9 error cleared by new start
    run_case(32'h0ABCDE, 11, 0, 1'b1, "R10");     // R10 longer stalled run

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule